// File: doc/BRIEF.md
# Character-Cell Text Display Controller

This block draws a monochrome text screen on a VGA-style monitor. The screen contents and the glyph shapes both live in an external byte-wide memory that other clients share. For every character cell on every visible scanline, the controller makes two reads. The first read gets the character code from the screen region. The second uses that code and the scanline within the cell to get one glyph byte. That byte is then shifted out most significant bit first as eight pixels. The controller also produces horizontal and vertical sync, and a single video bit that feeds all colour guns.

The memory port uses a request/acknowledge handshake. The request and its address stay constant until the memory answers. The answer arrives with a one-cycle acknowledge, so arbitration may delay each read by a few cycles. Raster timing is generated one cell width ahead of the visible outputs. This lets each cell's two reads run while the previous cell is still being shown. If the glyph byte for a cell is not in hand when its pixels are due, the cell is drawn blank and an underrun pulse is raised. The grid size, the porch and sync widths, the sync polarities and both memory base addresses are parameters. By default the grid is 70 by 28 cells of 8 by 16 pixels.

Top module: `vtxt_ctrl`

## Requirements
- R1: While reset is held and until the first cell is due, mem_req is 0, video is 0, underrun is 0, and both sync outputs sit at their inactive level (high for the default negative polarity).
- R2: hsync repeats every H_TOTAL = COLS*8 + H_FP + H_SYNC + H_BP cycles. It is active for H_SYNC cycles, starting COLS*8 + H_FP cycles after the first pixel of a line.
- R3: vsync repeats every V_TOTAL = ROWS*16 + V_FP + V_SYNC + V_BP lines. It is active for V_SYNC lines, starting ROWS*16 + V_FP lines after the first visible line.
- R4: For each visible cell (column c, text row r, scanline s within the cell) there are two reads. The first is at SCREEN_BASE + r*COLS + c. The second is at FONT_BASE + code*16 + s, where code is the byte returned by the first read. Cells are read left to right, line by line.
- R5: When every read is acknowledged within 2 cycles of its request being seen, each cell shows its glyph byte bit 7 first through bit 0 over eight consecutive pixels. There are no gaps and no underrun pulse.
- R6: video is 0 in every cycle outside the COLS*8 by ROWS*16 visible area.
- R7: Requests are issued only for visible cells. A full frame makes exactly 2*COLS*ROWS*16 acknowledged reads, and mem_req is never high during vertical blanking.
- R8: If the glyph byte of a cell has not arrived when its first pixel is due, all eight pixels of that cell are 0. underrun pulses for one cycle in that cell's first pixel slot. A byte that arrives late is never shown in a later cell.
- R9: Once raised, mem_req stays high and mem_addr stays unchanged until a cycle in which mem_ack is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | ADDR_W | Byte address of the pending read |
| mem_rdata | input | 8 | Read data, valid when mem_ack is 1 |
| mem_ack | input | 1 | One-cycle acknowledge of the pending read |
| hsync | output | 1 | Horizontal sync, polarity set by H_POS |
| vsync | output | 1 | Vertical sync, polarity set by V_POS |
| video | output | 1 | Monochrome pixel |
| underrun | output | 1 | One-cycle pulse when a cell is drawn blank for lack of data |

## Verification
The outputs lag the internal raster position by exactly eight cycles. The bench therefore counts cycles from the release of reset. At sample k it compares hsync, vsync and video against a model of position k-8, and treats every sample before eight as inactive. With a memory latency of L cycles, the glyph byte of a cell is held from 3+2L cycles after the cell's fetch slot begins. The byte is loaded at the end of that slot's eighth cycle. So L=1 and L=2 must give a perfect picture, and L=3 must give blank cells with underrun pulses aligned to each cell's first pixel. All observations are made on the falling clock edge. Addresses are checked in the cycle their acknowledge is visible.

// File: rtl/vtxt_pkg.sv
package vtxt_pkg;

    localparam int CELL_W     = 8;   // pixels per glyph row, equals memory width
    localparam int CELL_H     = 16;  // scanlines per character cell
    localparam int LINE_W     = 4;   // bits to index a scanline inside a cell
    localparam int CODE_W     = 8;
    localparam int GLYPH_OFS_W = CODE_W + LINE_W;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_CODE  = 2'd1,
        FS_GLYPH = 2'd2
    } fetch_state_e;

    typedef struct packed {
        logic [CODE_W-1:0] code;
        logic [LINE_W-1:0] line;
    } glyph_key_t;

    // Offset of a glyph row inside the font region: code*16 + scanline.
    function automatic logic [GLYPH_OFS_W-1:0] glyph_offset(glyph_key_t key);
        return {key.code, key.line};
    endfunction

    // Maps an internal "sync pulse on" flag to a pin level.
    function automatic logic sync_level(logic pulse_on, logic pos_polarity);
        return pos_polarity ? pulse_on : ~pulse_on;
    endfunction

endpackage

// File: rtl/vtxt_timing.sv
module vtxt_timing
    import vtxt_pkg::*;
#(
    parameter int COLS   = 70,
    parameter int ROWS   = 28,
    parameter int H_FP   = 96,
    parameter int H_SYNC = 96,
    parameter int H_BP   = 48,
    parameter int V_FP   = 45,
    parameter int V_SYNC = 2,
    parameter int V_BP   = 30,
    parameter int COL_W  = 7,
    parameter int ROW_W  = 5
) (
    input  logic             clk,
    input  logic             rst,
    output logic             vis,
    output logic             cell_start,
    output logic             cell_end,
    output logic             hs_on,
    output logic             vs_on,
    output logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] row,
    output logic [LINE_W-1:0] line
);
    localparam int H_ACT = COLS * CELL_W;
    localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP;
    localparam int V_ACT = ROWS * CELL_H;
    localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP;
    localparam int HC_W  = $clog2(H_TOT);
    localparam int VC_W  = $clog2(V_TOT);

    localparam logic [HC_W-1:0] HC_LAST   = HC_W'(H_TOT - 1);
    localparam logic [HC_W-1:0] HC_ACT    = HC_W'(H_ACT);
    localparam logic [HC_W-1:0] HS_BEGIN  = HC_W'(H_ACT + H_FP);
    localparam logic [HC_W-1:0] HS_FINISH = HC_W'(H_ACT + H_FP + H_SYNC);
    localparam logic [VC_W-1:0] VC_LAST   = VC_W'(V_TOT - 1);
    localparam logic [VC_W-1:0] VC_ACT    = VC_W'(V_ACT);
    localparam logic [VC_W-1:0] VS_BEGIN  = VC_W'(V_ACT + V_FP);
    localparam logic [VC_W-1:0] VS_FINISH = VC_W'(V_ACT + V_FP + V_SYNC);

    logic [HC_W-1:0] hc;
    logic [VC_W-1:0] vc;
    logic            line_wrap;

    assign line_wrap = (hc == HC_LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            hc <= '0;
            vc <= '0;
        end else begin
            hc <= line_wrap ? '0 : hc + 1'b1;
            if (line_wrap) begin
                vc <= (vc == VC_LAST) ? '0 : vc + 1'b1;
            end
        end
    end

    always_comb begin
        vis        = (hc < HC_ACT) && (vc < VC_ACT);
        cell_start = vis && (hc[2:0] == 3'd0);
        cell_end   = vis && (hc[2:0] == 3'd7);
        hs_on      = (hc >= HS_BEGIN) && (hc < HS_FINISH);
        vs_on      = (vc >= VS_BEGIN) && (vc < VS_FINISH);
        col        = COL_W'(hc >> 3);
        row        = ROW_W'(vc >> LINE_W);
        line       = vc[LINE_W-1:0];
    end

    // R2: the line counter wraps to zero after its last count
    assert_hc_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (hc == HC_LAST) |=> (hc == '0));

    // R3: the line index only moves at the end of a line
    assert_vc_step_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(vc) |-> ($past(hc) == HC_LAST));

endmodule

// File: rtl/vtxt_delay.sv
module vtxt_delay #(
    parameter int W     = 3,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) stage[g] <= '0;
                else     stage[g] <= d;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) stage[g] <= '0;
                else     stage[g] <= stage[g-1];
            end
        end
    end

    assign q = stage[DEPTH-1];

endmodule

// File: rtl/vtxt_fetch.sv
module vtxt_fetch
    import vtxt_pkg::*;
#(
    parameter int COLS        = 70,
    parameter int ADDR_W      = 17,
    parameter int SCREEN_BASE = 'h1000,
    parameter int FONT_BASE   = 0,
    parameter int COL_W       = 7,
    parameter int ROW_W       = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cell_start,
    input  logic              cell_end,
    input  logic [COL_W-1:0]  col,
    input  logic [ROW_W-1:0]  row,
    input  logic [LINE_W-1:0] line,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ack,
    output logic [7:0]        glyph,
    output logic              glyph_ok,
    output logic              underrun
);
    fetch_state_e      state;
    logic              stale;
    logic [LINE_W-1:0] line_q;
    logic [ADDR_W-1:0] screen_addr;
    logic [ADDR_W-1:0] font_addr;
    glyph_key_t        key;

    always_comb begin
        screen_addr = ADDR_W'(SCREEN_BASE) + ADDR_W'(row) * ADDR_W'(COLS) + ADDR_W'(col);
        key.code    = mem_rdata;
        key.line    = line_q;
        font_addr   = ADDR_W'(FONT_BASE) + ADDR_W'(glyph_offset(key));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= FS_IDLE;
            mem_req  <= 1'b0;
            mem_addr <= '0;
            line_q   <= '0;
            glyph    <= '0;
            glyph_ok <= 1'b0;
            stale    <= 1'b0;
            underrun <= 1'b0;
        end else begin
            underrun <= 1'b0;
            // The shifter takes the byte on this edge: consume or miss it.
            if (cell_end) begin
                if (!glyph_ok) underrun <= 1'b1;
                glyph_ok <= 1'b0;
                if (state != FS_IDLE) stale <= 1'b1;
            end
            unique case (state)
                FS_IDLE: begin
                    if (cell_start) begin
                        mem_req  <= 1'b1;
                        mem_addr <= screen_addr;
                        line_q   <= line;
                        state    <= FS_CODE;
                    end
                end
                FS_CODE: begin
                    if (mem_ack) begin
                        mem_addr <= font_addr;
                        state    <= FS_GLYPH;
                    end
                end
                FS_GLYPH: begin
                    if (mem_ack) begin
                        mem_req <= 1'b0;
                        glyph   <= mem_rdata;
                        state   <= FS_IDLE;
                        stale   <= 1'b0;
                        if (!stale && !cell_end) glyph_ok <= 1'b1;
                    end
                end
                default: state <= FS_IDLE;
            endcase
        end
    end

    // R9: a pending request is held with a stable address until acknowledged
    assert_req_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R4: a ready glyph byte is only produced after a code read and a glyph read
    assert_two_reads_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(glyph_ok) |-> ($past(mem_ack) && $past(state) == FS_GLYPH));

endmodule

// File: rtl/vtxt_shift.sv
module vtxt_shift
    import vtxt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              load_ok,
    input  logic [CELL_W-1:0] load_byte,
    output logic              pixel
);
    logic [CELL_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst)       sh <= '0;
        else if (load) sh <= load_ok ? load_byte : '0;
        else           sh <= {sh[CELL_W-2:0], 1'b0};
    end

    assign pixel = sh[CELL_W-1];

endmodule

// File: rtl/vtxt_ctrl.sv
module vtxt_ctrl
    import vtxt_pkg::*;
#(
    parameter int COLS        = 70,
    parameter int ROWS        = 28,
    parameter int H_FP        = 96,
    parameter int H_SYNC      = 96,
    parameter int H_BP        = 48,
    parameter int V_FP        = 45,
    parameter int V_SYNC      = 2,
    parameter int V_BP        = 30,
    parameter bit H_POS       = 1'b0,
    parameter bit V_POS       = 1'b0,
    parameter int ADDR_W      = 17,
    parameter int SCREEN_BASE = 'h1000,
    parameter int FONT_BASE   = 0
) (
    input  logic              clk,
    input  logic              rst,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ack,
    output logic              hsync,
    output logic              vsync,
    output logic              video,
    output logic              underrun
);
    localparam int COL_W = $clog2(COLS + 1);
    localparam int ROW_W = $clog2(ROWS + 1);

    logic              vis, cell_start, cell_end, hs_on, vs_on;
    logic [COL_W-1:0]  col;
    logic [ROW_W-1:0]  row;
    logic [LINE_W-1:0] line;
    logic [7:0]        glyph;
    logic              glyph_ok;
    logic              pixel;
    logic [2:0]        late_ctl;
    logic              hs_d, vs_d, vis_d;

    vtxt_timing #(
        .COLS(COLS), .ROWS(ROWS),
        .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
        .COL_W(COL_W), .ROW_W(ROW_W)
    ) u_timing (
        .clk(clk), .rst(rst),
        .vis(vis), .cell_start(cell_start), .cell_end(cell_end),
        .hs_on(hs_on), .vs_on(vs_on),
        .col(col), .row(row), .line(line)
    );

    vtxt_fetch #(
        .COLS(COLS), .ADDR_W(ADDR_W),
        .SCREEN_BASE(SCREEN_BASE), .FONT_BASE(FONT_BASE),
        .COL_W(COL_W), .ROW_W(ROW_W)
    ) u_fetch (
        .clk(clk), .rst(rst),
        .cell_start(cell_start), .cell_end(cell_end),
        .col(col), .row(row), .line(line),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .glyph(glyph), .glyph_ok(glyph_ok), .underrun(underrun)
    );

    vtxt_shift u_shift (
        .clk(clk), .rst(rst),
        .load(cell_end), .load_ok(glyph_ok), .load_byte(glyph),
        .pixel(pixel)
    );

    // Control timing trails the raster counters by one cell width.
    vtxt_delay #(.W(3), .DEPTH(CELL_W)) u_delay (
        .clk(clk), .rst(rst),
        .d({hs_on, vs_on, vis}),
        .q(late_ctl)
    );

    assign {hs_d, vs_d, vis_d} = late_ctl;
    assign hsync = sync_level(hs_d, H_POS);
    assign vsync = sync_level(vs_d, V_POS);
    assign video = vis_d & pixel;

    // R7: a new request is started only from a visible cell
    assert_req_visible_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_req) |-> $past(vis));

    // R8: a cell flagged as underrun shows no lit pixel in its first slot
    assert_underrun_dark_R8: assert property (@(posedge clk) disable iff (rst)
        underrun |-> !video);

endmodule

// File: tb/vtxt_ctrl_tb.sv
module vtxt_ctrl_tb;

    localparam int COLS   = 4;
    localparam int ROWS   = 2;
    localparam int H_FP   = 4;
    localparam int H_SYNC = 4;
    localparam int H_BP   = 8;
    localparam int V_FP   = 2;
    localparam int V_SYNC = 2;
    localparam int V_BP   = 2;
    localparam int ADDR_W = 12;
    localparam int SBASE  = 'h800;
    localparam int FBASE  = 0;
    localparam int H_ACT  = COLS * 8;
    localparam int V_ACT  = ROWS * 16;
    localparam int HT     = H_ACT + H_FP + H_SYNC + H_BP;
    localparam int VT     = V_ACT + V_FP + V_SYNC + V_BP;
    localparam int FRAME  = HT * VT;
    localparam int LAG    = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_rdata = '0;
    logic              mem_ack = 1'b0;
    logic              hsync, vsync, video, underrun;

    logic [7:0] mem [4096];
    int lat  = 1;
    int seed = 0;
    int cnt  = 0;
    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    vtxt_ctrl #(
        .COLS(COLS), .ROWS(ROWS),
        .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
        .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
        .H_POS(1'b0), .V_POS(1'b0),
        .ADDR_W(ADDR_W), .SCREEN_BASE(SBASE), .FONT_BASE(FBASE)
    ) u_dut (
        .clk(clk), .rst(rst),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .hsync(hsync), .vsync(vsync), .video(video), .underrun(underrun)
    );

    // Shared memory model: acknowledges lat cycles after a request is seen.
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            cnt     <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
            cnt     <= 0;
        end else if (mem_req) begin
            if (cnt >= lat - 1) begin
                mem_ack   <= 1'b1;
                mem_rdata <= mem[mem_addr];
                cnt       <= 0;
            end else begin
                cnt <= cnt + 1;
            end
        end else begin
            cnt <= 0;
        end
    end

    function automatic int scr_code(int r, int c);
        return (seed * 11 + r * COLS + c * 3 + 1) % 128;
    endfunction

    function automatic logic [7:0] font_byte(int code, int ln);
        return 8'((code * 29 + ln * 13 + seed * 5) ^ (ln * 16));
    endfunction

    task automatic check(input bit ok, input string tag, input int actual, input int expected);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic load_memory();
        for (int a = 0; a < 4096; a++) mem[a] = 8'h00;
        for (int c = 0; c < 128; c++)
            for (int l = 0; l < 16; l++)
                mem[FBASE + c * 16 + l] = font_byte(c, l);
        for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
                mem[SBASE + r * COLS + c] = 8'(scr_code(r, c));
    endtask

    task automatic restart(input int new_lat, input int new_seed);
        @(negedge clk);
        rst  = 1'b1;
        lat  = new_lat;
        seed = new_seed;
        load_memory();
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    // R1: reset values at the ports
    task automatic test_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (4) @(negedge clk);
        check(mem_req == 1'b0 && underrun == 1'b0, "R1 req/underrun in reset",
              {mem_req, underrun}, 0);
        check(video == 1'b0 && hsync == 1'b1 && vsync == 1'b1, "R1 video/syncs in reset",
              {video, hsync, vsync}, 3);
    endtask

    // Runs one frame from reset release and compares every output with the model.
    task automatic run_frame(input int new_lat, input int new_seed, input bit late);
        int hs_err = 0, vs_err = 0, vin_err = 0, vout_err = 0;
        int addr_err = 0, acks = 0, und = 0, vb_req = 0, hold_err = 0;
        int first_bad = -1;
        logic              p_req = 1'b0, p_ack = 1'b0;
        logic [ADDR_W-1:0] p_addr = '0;
        restart(new_lat, new_seed);
        for (int k = 0; k < FRAME + LAG; k++) begin
            logic e_hs, e_vs, e_vid;
            e_hs = 1'b1; e_vs = 1'b1; e_vid = 1'b0;
            if (k >= LAG) begin
                int p, x, y;
                p = k - LAG;
                x = p % HT;
                y = (p / HT) % VT;
                e_hs = !(x >= H_ACT + H_FP && x < H_ACT + H_FP + H_SYNC);
                e_vs = !(y >= V_ACT + V_FP && y < V_ACT + V_FP + V_SYNC);
                if (x < H_ACT && y < V_ACT) begin
                    logic [7:0] gb;
                    gb = font_byte(scr_code(y / 16, x / 8), y % 16);
                    e_vid = late ? 1'b0 : gb[7 - (x % 8)];
                    if (video !== e_vid) begin
                        vin_err++;
                        if (first_bad < 0) first_bad = k;
                    end
                end else if (video !== 1'b0) begin
                    vout_err++;
                end
            end else if (video !== 1'b0) begin
                vout_err++;
            end
            if (hsync !== e_hs) hs_err++;
            if (vsync !== e_vs) vs_err++;
            if (underrun === 1'b1) und++;
            if (k < FRAME) begin
                if ((k / HT) % VT >= V_ACT && mem_req) vb_req++;
                if (mem_ack) begin
                    int pr, lg, c, r, ex;
                    pr = acks / 2;
                    lg = (pr / COLS) % V_ACT;
                    c  = pr % COLS;
                    r  = lg / 16;
                    if (acks % 2 == 0) ex = SBASE + r * COLS + c;
                    else               ex = FBASE + scr_code(r, c) * 16 + lg % 16;
                    if (!late && int'(mem_addr) != ex) addr_err++;
                    acks++;
                end
            end
            if (p_req && !p_ack && !(mem_req && mem_addr == p_addr)) hold_err++;
            p_req  = mem_req;
            p_ack  = mem_ack;
            p_addr = mem_addr;
            @(negedge clk);
        end
        check(hs_err == 0, "R2 hsync timing mismatches", hs_err, 0);
        check(vs_err == 0, "R3 vsync timing mismatches", vs_err, 0);
        check(vout_err == 0, "R6 video outside visible area", vout_err, 0);
        check(vb_req == 0, "R7 requests in vertical blank", vb_req, 0);
        check(hold_err == 0, "R9 request/address not held", hold_err, 0);
        if (!late) begin
            check(vin_err == 0, $sformatf("R5 pixel mismatches (first at sample %0d)", first_bad),
                  vin_err, 0);
            check(und == 0, "R5 underrun pulses at in-bound latency", und, 0);
            check(addr_err == 0, "R4 read address order", addr_err, 0);
            check(acks == 2 * COLS * V_ACT, "R7 reads per frame", acks, 2 * COLS * V_ACT);
        end else begin
            check(vin_err == 0, "R8 late cells not blank", vin_err, 0);
            check(und == COLS * V_ACT, "R8 underrun pulses per frame", und, COLS * V_ACT);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        test_reset();
        run_frame(1, 3, 1'b0);
        run_frame(2, 9, 1'b0);
        run_frame(3, 5, 1'b1);
        run_frame(1, 14, 1'b0);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule